// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block sits beside a small 32-bit core. At each instruction boundary it picks which pending interrupt the core takes. It then performs the architectural entry step. The block owns the status word, the exception cause register and two save pairs: one for the non-maskable level and one for the maskable level. When it accepts an entry, it sends the core a one-cycle redirect carrying the target address.

There are three kinds of request. A reset request and a non-maskable (NMI) request are honoured whatever the interrupt-disable bit says. Six maskable lines are honoured only while that bit is clear. A non-maskable request that arrives while an earlier one is still in service is not taken. Instead it is held in a single pending flag and taken later. The return path is out of scope, so two simple stand-ins are provided. A one-cycle "service done" pulse clears the in-service bit, and a status-word write port lets the core re-enable maskable interrupts.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A maskable line is taken only when status bit 5 (interrupt-disable) is 0. While that bit is 1, maskable requests cause no redirect and change no saved state.
- R2: Every accepted entry leaves status bit 5 set to 1 and status bit 6 (exception-pending) cleared to 0.
- R3: A reset entry redirects to address 0. It sets the status word to 0x20 and the cause register to 0, and it drops any held non-maskable request.
- R4: A non-maskable entry does four things:
  - it copies the boundary PC and the old status word into the non-maskable save pair;
  - it writes 0x0010 into cause bits 31:16 and keeps bits 15:0;
  - it sets status bit 7 (in-service);
  - it redirects to 0x10.
- R5: A non-maskable request seen while status bit 7 is 1 is not taken. It sets one held flag, and further requests are not counted. The held request is taken at the first boundary after bit 7 clears, and only once.
- R6: A maskable entry does three things:
  - it copies the boundary PC and the old status word into the maskable save pair;
  - it writes the vector into cause bits 15:0 and keeps bits 31:16;
  - it redirects to the vector.
- R7: Maskable line i (0 to 5) uses vector 0x80 + 0x10*i, so the vectors are 0x80, 0x90, 0xA0, 0xB0, 0xC0 and 0xD0.
- R8: Priority is fixed. Reset comes first, then non-maskable, then the maskable line with the lowest index. At most one entry is accepted per cycle.
- R9: An entry is accepted only in a cycle where the boundary strobe is 1. The redirect output pulses for exactly the one cycle after that edge.
- R10: In a cycle with no entry, the status write port loads the status word. The service-done pulse clears only status bit 7.
- R11: After synchronous reset:
  - the status word is 0x20;
  - the cause register and all save registers are 0;
  - the held flag and the redirect output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary; entry allowed this cycle |
| reset_req_i | input | 1 | Reset interrupt request |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| mask_req_i | input | 6 | Maskable request lines, index 0 highest priority |
| pc_i | input | 32 | PC to resume at, saved on entry |
| psw_wr_i | input | 1 | Status word write enable |
| psw_wdata_i | input | 32 | Status word write data |
| nmi_done_i | input | 1 | Clears the non-maskable in-service bit |
| redirect_o | output | 1 | One-cycle entry pulse |
| redirect_pc_o | output | 32 | Entry target address |
| psw_o | output | 32 | Current status word |
| cause_o | output | 32 | Exception cause register |
| nmi_save_pc_o | output | 32 | Non-maskable saved PC |
| nmi_save_psw_o | output | 32 | Non-maskable saved status word |
| int_save_pc_o | output | 32 | Maskable saved PC |
| int_save_psw_o | output | 32 | Maskable saved status word |
| nmi_held_o | output | 1 | A non-maskable request is held |

## Verification
The bench presents maskable lines while interrupts are disabled. A design that ignores the disable bit would redirect there and overwrite the maskable save pair.

It repeats non-maskable pulses during service, then releases service. A design that counts requests would enter twice, and one that loses the held flag would never enter.

Requests from all three classes arrive at once on a reset boundary. This exposes a wrong priority order, and also a held flag that survives reset entry.

A six-line sweep with two lines active together checks every vector, lowest-index selection, and that the two cause halves are written separately.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int XLEN       = 32;
    localparam int HALF_W     = XLEN / 2;
    localparam int NUM_MASK   = 6;
    localparam int LINE_W     = $clog2(NUM_MASK);
    localparam int ID_BIT     = 5;
    localparam int EP_BIT     = 6;
    localparam int NP_BIT     = 7;

    localparam logic [XLEN-1:0] RESET_PSW   = 32'h0000_0020;
    localparam logic [XLEN-1:0] NMI_VECTOR  = 32'h0000_0010;
    localparam logic [XLEN-1:0] MASK_BASE   = 32'h0000_0080;
    localparam logic [XLEN-1:0] MASK_STRIDE = 32'h0000_0010;

    typedef enum logic [1:0] {
        ENT_NONE,
        ENT_RESET,
        ENT_NMI,
        ENT_MASK
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e         kind;
        logic [LINE_W-1:0]   line;
    } entry_sel_t;

    function automatic logic [XLEN-1:0] mask_vector(input logic [LINE_W-1:0] line);
        return MASK_BASE + MASK_STRIDE * XLEN'(line);
    endfunction

    function automatic logic [XLEN-1:0] entered_psw(input logic [XLEN-1:0] p);
        logic [XLEN-1:0] r;
        r         = p;
        r[ID_BIT] = 1'b1;
        r[EP_BIT] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/irq_select.sv
module irq_select
    import irq_entry_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                boundary,
    input  logic                reset_req,
    input  logic                nmi_want,
    input  logic                nmi_busy,
    input  logic                int_disabled,
    input  logic [NUM_MASK-1:0] mask_req,
    output entry_sel_t          sel
);
    always_comb begin
        sel.kind = ENT_NONE;
        sel.line = '0;
        if (boundary) begin
            if (reset_req) begin
                sel.kind = ENT_RESET;
            end else if (nmi_want && !nmi_busy) begin
                sel.kind = ENT_NMI;
            end else if (!int_disabled && (|mask_req)) begin
                sel.kind = ENT_MASK;
                // descending scan: the last hit is the lowest index
                for (int i = NUM_MASK - 1; i >= 0; i--) begin
                    if (mask_req[i]) sel.line = LINE_W'(i);
                end
            end
        end
    end

    AST_MASK_LINE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (sel.kind == ENT_MASK) |-> (mask_req[sel.line] && !int_disabled)); // R1

    AST_MASK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (sel.kind == ENT_MASK) |->
            ((mask_req & ((NUM_MASK'(1) << sel.line) - NUM_MASK'(1))) == '0)); // R8
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic take,
    input  logic drop,
    output logic held,
    output logic want
);
    assign want = held | nmi_req;

    always_ff @(posedge clk) begin
        if (rst || drop || take) begin
            held <= 1'b0;
        end else if (nmi_req) begin
            held <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                boundary_i,
    input  logic                reset_req_i,
    input  logic                nmi_req_i,
    input  logic [NUM_MASK-1:0] mask_req_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic                psw_wr_i,
    input  logic [XLEN-1:0]     psw_wdata_i,
    input  logic                nmi_done_i,
    output logic                redirect_o,
    output logic [XLEN-1:0]     redirect_pc_o,
    output logic [XLEN-1:0]     psw_o,
    output logic [XLEN-1:0]     cause_o,
    output logic [XLEN-1:0]     nmi_save_pc_o,
    output logic [XLEN-1:0]     nmi_save_psw_o,
    output logic [XLEN-1:0]     int_save_pc_o,
    output logic [XLEN-1:0]     int_save_psw_o,
    output logic                nmi_held_o
);
    logic [XLEN-1:0] psw_q, cause_q, fepc_q, fepsw_q, eipc_q, eipsw_q;
    logic [XLEN-1:0] psw_next, redir_pc_q;
    logic            redir_q;
    logic            nmi_want;
    entry_sel_t      sel;

    irq_select u_select (
        .clk          (clk),
        .rst          (rst),
        .boundary     (boundary_i),
        .reset_req    (reset_req_i),
        .nmi_want     (nmi_want),
        .nmi_busy     (psw_q[NP_BIT]),
        .int_disabled (psw_q[ID_BIT]),
        .mask_req     (mask_req_i),
        .sel          (sel)
    );

    nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_req (nmi_req_i),
        .take    (sel.kind == ENT_NMI),
        .drop    (sel.kind == ENT_RESET),
        .held    (nmi_held_o),
        .want    (nmi_want)
    );

    always_comb begin
        psw_next = psw_q;
        unique case (sel.kind)
            ENT_RESET: psw_next = RESET_PSW;
            ENT_NMI: begin
                psw_next         = entered_psw(psw_q);
                psw_next[NP_BIT] = 1'b1;
            end
            ENT_MASK: begin
                psw_next = entered_psw(psw_q);
                if (nmi_done_i) psw_next[NP_BIT] = 1'b0;
            end
            default: begin
                if (psw_wr_i) psw_next = psw_wdata_i;
                if (nmi_done_i) psw_next[NP_BIT] = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q      <= RESET_PSW;
            cause_q    <= '0;
            fepc_q     <= '0;
            fepsw_q    <= '0;
            eipc_q     <= '0;
            eipsw_q    <= '0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
        end else begin
            psw_q   <= psw_next;
            redir_q <= (sel.kind != ENT_NONE);
            unique case (sel.kind)
                ENT_RESET: begin
                    cause_q    <= '0;
                    redir_pc_q <= '0;
                end
                ENT_NMI: begin
                    fepc_q     <= pc_i;
                    fepsw_q    <= psw_q;
                    cause_q    <= {NMI_VECTOR[HALF_W-1:0], cause_q[HALF_W-1:0]};
                    redir_pc_q <= NMI_VECTOR;
                end
                ENT_MASK: begin
                    eipc_q     <= pc_i;
                    eipsw_q    <= psw_q;
                    cause_q    <= {cause_q[XLEN-1:HALF_W], mask_vector(sel.line)[HALF_W-1:0]};
                    redir_pc_q <= mask_vector(sel.line);
                end
                default: ;
            endcase
        end
    end

    assign redirect_o     = redir_q;
    assign redirect_pc_o  = redir_pc_q;
    assign psw_o          = psw_q;
    assign cause_o        = cause_q;
    assign nmi_save_pc_o  = fepc_q;
    assign nmi_save_psw_o = fepsw_q;
    assign int_save_pc_o  = eipc_q;
    assign int_save_psw_o = eipsw_q;

    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (rst)
        redir_q |-> (psw_q[ID_BIT] && !psw_q[EP_BIT])); // R2

    AST_ENTRY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        redir_q |-> $past(boundary_i)); // R9

    AST_NMI_MARKS_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (redir_q && redir_pc_q == NMI_VECTOR) |-> psw_q[NP_BIT]); // R4

    AST_NMI_NOT_NESTED: assert property (@(posedge clk) disable iff (rst)
        (redir_q && redir_pc_q == NMI_VECTOR) |-> !$past(psw_q[NP_BIT])); // R5

    AST_MASK_WAS_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (redir_q && redir_pc_q[7]) |-> !$past(psw_q[ID_BIT])); // R1

    AST_MASK_CAUSE_CODE: assert property (@(posedge clk) disable iff (rst)
        (redir_q && redir_pc_q[7]) |-> (cause_q[HALF_W-1:0] == redir_pc_q[HALF_W-1:0])); // R6

    AST_RESET_CLEARS_HELD: assert property (@(posedge clk) disable iff (rst)
        (redir_q && redir_pc_q == '0) |-> !nmi_held_o); // R3
endmodule

// File: tb/tb_irq_entry_ctrl.sv
`timescale 1ns/1ps
module tb_irq_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        boundary_i, reset_req_i, nmi_req_i, psw_wr_i, nmi_done_i;
    logic [5:0]  mask_req_i;
    logic [31:0] pc_i, psw_wdata_i;
    logic        redirect_o, nmi_held_o;
    logic [31:0] redirect_pc_o, psw_o, cause_o;
    logic [31:0] nmi_save_pc_o, nmi_save_psw_o, int_save_pc_o, int_save_psw_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_entry_ctrl dut (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .reset_req_i(reset_req_i),
        .nmi_req_i(nmi_req_i), .mask_req_i(mask_req_i), .pc_i(pc_i),
        .psw_wr_i(psw_wr_i), .psw_wdata_i(psw_wdata_i), .nmi_done_i(nmi_done_i),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .psw_o(psw_o),
        .cause_o(cause_o), .nmi_save_pc_o(nmi_save_pc_o), .nmi_save_psw_o(nmi_save_psw_o),
        .int_save_pc_o(int_save_pc_o), .int_save_psw_o(int_save_psw_o),
        .nmi_held_o(nmi_held_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        boundary_i = 0; reset_req_i = 0; nmi_req_i = 0; mask_req_i = '0;
        psw_wr_i = 0; psw_wdata_i = '0; nmi_done_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic write_psw(input logic [31:0] v);
        psw_wr_i = 1; psw_wdata_i = v;
        step();
    endtask

    task automatic t_reset_state();
        chk("R11 psw", psw_o, 32'h20);
        chk("R11 cause", cause_o, 32'h0);
        chk("R11 held", {31'b0, nmi_held_o}, 32'h0);
        chk("R11 redirect", {31'b0, redirect_o}, 32'h0);
        chk("R11 int save pc", int_save_pc_o, 32'h0);
    endtask

    task automatic t_mask_blocked();
        boundary_i = 1; mask_req_i = 6'b000100; pc_i = 32'h4444;
        step();
        chk("R1 no redirect when disabled", {31'b0, redirect_o}, 32'h0);
        chk("R1 save untouched", int_save_pc_o, 32'h0);
        write_psw(32'h0);
        chk("R10 psw write", psw_o, 32'h0);
        boundary_i = 1; mask_req_i = 6'b010100; pc_i = 32'h1234;
        step();
        chk("R8 lowest line wins", redirect_pc_o, 32'hA0);
        chk("R9 redirect pulse", {31'b0, redirect_o}, 32'h1);
        chk("R6 saved pc", int_save_pc_o, 32'h1234);
        chk("R6 saved psw", int_save_psw_o, 32'h0);
        chk("R2 psw after entry", psw_o, 32'h20);
        chk("R6 cause", cause_o, 32'hA0);
        step();
        chk("R9 pulse one cycle", {31'b0, redirect_o}, 32'h0);
    endtask

    task automatic t_vectors();
        for (int i = 0; i < 6; i++) begin
            write_psw(32'h0);
            boundary_i = 1; mask_req_i = 6'(1 << i); pc_i = 32'h100 + i;
            step();
            chk("R7 vector", redirect_pc_o, 32'h80 + 32'h10 * i);
            chk("R6 cause low", cause_o, 32'h80 + 32'h10 * i);
        end
    endtask

    task automatic t_no_boundary();
        write_psw(32'h0);
        mask_req_i = 6'b000001;
        step();
        chk("R9 no entry off boundary", {31'b0, redirect_o}, 32'h0);
        chk("R9 psw kept", psw_o, 32'h0);
    endtask

    task automatic t_nmi();
        write_psw(32'h41);
        boundary_i = 1; nmi_req_i = 1; mask_req_i = 6'b000001; pc_i = 32'h2000;
        step();
        chk("R8 nmi over maskable", redirect_pc_o, 32'h10);
        chk("R4 saved pc", nmi_save_pc_o, 32'h2000);
        chk("R4 saved psw", nmi_save_psw_o, 32'h41);
        chk("R4 psw", psw_o, 32'hA1);
        chk("R4 cause halves", cause_o, 32'h0010_00D0);
        chk("R8 maskable save untouched", int_save_pc_o, 32'h105);
    endtask

    task automatic t_nmi_held();
        boundary_i = 1; nmi_req_i = 1; pc_i = 32'h2222;
        step();
        chk("R5 not nested", {31'b0, redirect_o}, 32'h0);
        boundary_i = 1; nmi_req_i = 1;
        step();
        chk("R5 held", {31'b0, nmi_held_o}, 32'h1);
        chk("R5 save kept", nmi_save_pc_o, 32'h2000);
        nmi_done_i = 1;
        step();
        chk("R10 done clears bit7", psw_o, 32'h21);
        boundary_i = 1; pc_i = 32'h3000;
        step();
        chk("R5 held taken", redirect_pc_o, 32'h10);
        chk("R5 held taken pulse", {31'b0, redirect_o}, 32'h1);
        chk("R5 held cleared", {31'b0, nmi_held_o}, 32'h0);
        chk("R4 saved pc 2", nmi_save_pc_o, 32'h3000);
        chk("R4 saved psw 2", nmi_save_psw_o, 32'h21);
        nmi_done_i = 1;
        step();
        boundary_i = 1;
        step();
        chk("R5 taken only once", {31'b0, redirect_o}, 32'h0);
    endtask

    task automatic t_reset_entry();
        nmi_req_i = 1;
        step();
        nmi_done_i = 0;
        write_psw(32'hA0);
        nmi_req_i = 1;
        step();
        chk("R5 held before reset", {31'b0, nmi_held_o}, 32'h1);
        boundary_i = 1; reset_req_i = 1; nmi_req_i = 1; mask_req_i = 6'h3F;
        step();
        chk("R3 redirect", {31'b0, redirect_o}, 32'h1);
        chk("R3 target", redirect_pc_o, 32'h0);
        chk("R3 psw", psw_o, 32'h20);
        chk("R3 cause", cause_o, 32'h0);
        chk("R3 held dropped", {31'b0, nmi_held_o}, 32'h0);
    endtask

    initial begin
        idle();
        pc_i = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset_state();
        t_mask_blocked();
        t_vectors();
        t_no_boundary();
        t_nmi();
        t_nmi_held();
        t_reset_entry();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule